// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block is the register front end of a PS/2 keyboard or mouse host port. A processor reaches it through a simple register bus with 32-bit words. The bus has a byte address, a read strobe, a write strobe, write data and read data. On the device side the block takes received bytes through a valid/pop handshake. It sends bytes to be transmitted as a one-cycle strobe with the byte alongside. It also drives one level-sensitive interrupt line.

Software sees these registers:

- control;
- status, which reports receive-pending and the odd parity of the last byte read;
- data, which is read to receive and written to transmit;
- clock divider, which is plain storage;
- interrupt identification;
- an eight-byte identification window at the top of the 4 KiB region.

The serial line protocol, the use of the divider and the enable control all sit outside this block. Transmit always reports empty. So the transmit interrupt enable raises the interrupt line for as long as it is set.

Top module: `ps2_host_regs`

## Requirements

- R1: After reset, control, clock divider, the last received byte and read data are all zero. The interrupt output and the transmit strobe are low.
- R2: The word index is the byte address shifted right by two. Word 0 (control) and word 3 (clock divider) store a full 32-bit write and read it back. Address bits 1:0 are ignored.
- R3: Reading word 1 (status) returns bit 6 = 1, bit 4 = receive pending, and bit 2 = the XOR of all eight bits of the last latched byte. Every other bit reads 0, including bit 5 and bit 3.
- R4: A read of word 2 (data) while device-side valid is high pulses pop in that same cycle and latches the incoming byte. The read returns that byte, zero-extended.
- R5: A read of word 2 while valid is low does not pop. It returns the previously latched byte again.
- R6: A write to word 2 sets the transmit strobe high for exactly one cycle, on the cycle after the write. During that cycle the transmit byte carries write data bits 7:0.
- R7: The interrupt output equals (valid AND control bit 4) OR control bit 3. It follows changes of valid and control without further delay.
- R8: Reading word 4 (interrupt identification) returns bit 0 = receive pending and bit 1 = 1. All other bits are 0.
- R9: Byte addresses 0xFE0 to 0xFFF read an identification byte indexed by address bits 4:2. The bytes for index 0 to 7 are 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of any other address return 0. Writes to status, interrupt identification, the identification window or an undefined address change no register and raise no transmit strobe.
- R11: Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the register access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| rx_byte | input | 8 | Received byte from the device side |
| rx_valid | input | 1 | A received byte is pending |
| rx_pop | output | 1 | Consumes the pending byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit request |
| irq | output | 1 | Level interrupt |

## Verification

The data register is read twice for each received byte, once with valid high and once with it low. This separates a real pop-and-latch from a replay of the old byte. The received bytes are chosen so that one has an odd number of set bits and one an even number, so the live status parity must change between them. The interrupt line is driven through each combination of valid and the two control enables, which separates the receive term from the always-on transmit term. The identification table is swept entry by entry, then writes land on every read-only or undefined address before control and divider are read back unchanged.

// File: rtl/ps2_host_regs.sv
module ps2_host_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_pop,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_strobe,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word;
  logic [DATA_W-1:0] ctrl_r, div_r, rd_mux;
  logic [BYTE_W-1:0] last_r, id_byte;
  logic hit_ctrl, hit_stat, hit_data, hit_div, hit_iir, hit_id;

  assign word     = addr[ADDR_W-1:2];
  assign hit_ctrl = word == WIDX_W'(0);
  assign hit_stat = word == WIDX_W'(1);
  assign hit_data = word == WIDX_W'(2);
  assign hit_div  = word == WIDX_W'(3);
  assign hit_iir  = word == WIDX_W'(4);
  assign hit_id   = &word[WIDX_W-1:3];

  assign rx_pop = rd_en && hit_data && rx_valid;
  assign irq    = (rx_valid && ctrl_r[4]) || ctrl_r[3];

  always_comb begin
    case (word[2:0])
      3'd0: id_byte = BYTE_W'(8'h50);
      3'd1: id_byte = BYTE_W'(8'h10);
      3'd2: id_byte = BYTE_W'(8'h04);
      3'd3: id_byte = BYTE_W'(8'h00);
      3'd4: id_byte = BYTE_W'(8'h0D);
      3'd5: id_byte = BYTE_W'(8'hF0);
      3'd6: id_byte = BYTE_W'(8'h05);
      default: id_byte = BYTE_W'(8'hB1);
    endcase
  end

  always_comb begin
    rd_mux = '0;
    if (hit_id)        rd_mux = DATA_W'(id_byte);
    else if (hit_ctrl) rd_mux = ctrl_r;
    else if (hit_stat) rd_mux = DATA_W'({1'b1, 1'b0, rx_valid, 1'b0, ^last_r, 2'b00});
    else if (hit_data) rd_mux = DATA_W'(rx_pop ? rx_byte : last_r);
    else if (hit_div)  rd_mux = div_r;
    else if (hit_iir)  rd_mux = DATA_W'({1'b1, rx_valid});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r    <= '0;
      div_r     <= '0;
      last_r    <= '0;
      rdata     <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (wr_en) begin
        if (hit_ctrl) ctrl_r <= wdata;
        if (hit_div)  div_r  <= wdata;
        if (hit_data) begin
          tx_byte   <= wdata[BYTE_W-1:0];
          tx_strobe <= 1'b1;
        end
      end
      if (rd_en) begin
        if (rx_pop) last_r <= rx_byte;
        rdata <= rd_mux;
      end
    end
  end

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid && rd_en); // R4
  AST_POP_RETURNS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> rdata == DATA_W'($past(rx_byte))); // R4
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_data) |=> tx_strobe && tx_byte == $past(wdata[BYTE_W-1:0])); // R6
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_data) |=> !tx_strobe); // R6
  AST_TX_IRQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctrl && wdata[3]) |=> irq); // R7
  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_stat && !hit_id) |=> rdata[6] && !rdata[5] && !rdata[3]); // R3
  AST_IIR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_iir) |=> rdata == DATA_W'({1'b1, $past(rx_valid)})); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
endmodule

// File: tb/ps2_host_regs_bench.sv
`timescale 1ns/1ps
module ps2_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_pop;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic        rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ps2_host_regs u_ps2_host_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;

  initial begin
    forever begin
      @(negedge clk);
      if (rd_d) begin
        if (exp_q.size() == 0) check("R11 unexpected read", rdata, 32'hDEAD_BEEF);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic exp_pop, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    #2 check({tag, " pop"}, 32'(rx_pop), 32'(exp_pop));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [7:0] IDV [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_strobe", 32'(tx_strobe), 0);
    check("R1 rdata", rdata, 0);
    rd(12'h000, 32'h0, 1'b0, "R1 ctrl");
    rd(12'h00C, 32'h0, 1'b0, "R1 div");
    rd(12'h008, 32'h0, 1'b0, "R1 data");

    wr(12'h000, 32'hCAFE_0010);
    wr(12'h00C, 32'h1234_56A5);
    rd(12'h002, 32'hCAFE_0010, 1'b0, "R2 ctrl low addr bits");
    rd(12'h00F, 32'h1234_56A5, 1'b0, "R2 div");
    rd(12'h008, 32'h0, 1'b0, "R11 back-to-back");

    check("R7 enabled no data", 32'(irq), 0);
    rx_valid = 1'b1; #1;
    check("R7 enabled with data", 32'(irq), 1);
    wr(12'h000, 32'h0);
    check("R7 disabled with data", 32'(irq), 0);
    rx_valid = 1'b0;
    wr(12'h000, 32'h8);
    check("R7 tx enable forces", 32'(irq), 1);
    wr(12'h000, 32'h0);
    check("R7 all off", 32'(irq), 0);

    rx_valid = 1'b1; rx_byte = 8'h37;
    rd(12'h004, 32'h50, 1'b0, "R3 status pending");
    rd(12'h010, 32'h3, 1'b0, "R8 iir pending");
    rd(12'h008, 32'h37, 1'b1, "R4 pop 0x37");
    rx_valid = 1'b0; rx_byte = 8'hEE;
    rd(12'h004, 32'h44, 1'b0, "R3 odd parity");
    rd(12'h008, 32'h37, 1'b0, "R5 replay");
    rd(12'h010, 32'h2, 1'b0, "R8 iir idle");
    rx_valid = 1'b1; rx_byte = 8'h3C;
    rd(12'h008, 32'h3C, 1'b1, "R4 pop 0x3C");
    rx_valid = 1'b0;
    rd(12'h004, 32'h40, 1'b0, "R3 even parity");

    wr(12'h008, 32'h0001_235A);
    check("R6 strobe", 32'(tx_strobe), 1);
    check("R6 byte", 32'(tx_byte), 32'h5A);
    @(negedge clk);
    check("R6 single cycle", 32'(tx_strobe), 0);

    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(4 * i), 32'(IDV[i]), 1'b0, "R9 id byte");

    rd(12'h014, 32'h0, 1'b0, "R10 undefined 0x14");
    rd(12'h800, 32'h0, 1'b0, "R10 undefined 0x800");
    wr(12'h004, 32'hFFFF_FFFF);
    check("R10 no strobe status", 32'(tx_strobe), 0);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'hFE0, 32'hFFFF_FFFF);
    check("R10 no strobe id", 32'(tx_strobe), 0);
    check("R10 irq", 32'(irq), 0);
    rd(12'h000, 32'h0, 1'b0, "R10 ctrl kept");
    rd(12'h00C, 32'h1234_56A5, 1'b0, "R10 div kept");
    rd(12'h008, 32'h3C, 1'b0, "R10 data kept");
    rd(12'hFE4, 32'h10, 1'b0, "R10 id kept");
    repeat (2) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule